// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog counter whose setup comes from a static configuration byte captured while reset is held. The byte chooses whether the watchdog runs, how long the timeout period is, and what share of that period forms the "open" window in which software may service it. Software services the watchdog by writing a fixed 8-bit key to a bus-mapped service register; a correct key inside the open window clears the counter so that it counts up from zero again.

Any misuse ends in a one-cycle internal reset request with a 2-bit cause code: the count reaching its terminal value, a write of any value other than the key, a single-bit manipulation of the service register (signalled by a dedicated strobe), a key written while the window is still closed, or an illegal memory access flag raised by the surrounding system. The first key after reset, or after a reset request, is accepted at any count. After each request the counter and the first-key state return to their reset values while the captured configuration is kept. Reading the service register always returns a constant and changes nothing.

Top module: `keyed_window_watchdog`

## Requirements
- R1: The configuration byte is captured only while `rst_n` is low: bit 4 is the run enable, bits 3:1 are the period select n, bits 6:5 are the window select w; changing `cfg_byte` after reset release has no effect.
- R2: With the watchdog running, the terminal count is T = 2^(10+min(n,6)) - 1 (so n=6 and n=7 both give 0xFFFF); with no valid key, `rst_req` is high for exactly the cycle after T+1 rising edges following reset release or the last clear, with cause code 00.
- R3: A write of 0xAC to the service register clears the counter; a key write made in the cycle when the count equals T is valid and prevents the overflow.
- R4: The first key write after reset release, or after any reset request, is accepted whatever the count value.
- R5: From the second key write on, with P = T+1, the window is open when count >= (P/4)*(3-w) (w=00: last 25 %, 01: last 50 %, 10: last 75 %, 11: always open); a key written while closed raises a request with cause 10.
- R6: Writing any value other than 0xAC raises a request with cause 01.
- R7: Asserting the single-bit manipulation strobe `bit_op` raises a request with cause 01, whatever the data.
- R8: With the watchdog running, `illegal_acc` raises a request with cause 11; with the watchdog disabled it is ignored.
- R9: With the watchdog disabled the counter stays stopped and never overflows, key writes are still checked for value (cause 01) and correct keys are always accepted.
- R10: A request is a single-cycle pulse; afterwards the counter restarts from zero and the first-key exemption applies again.
- R11: When several causes occur in one cycle, the reported cause follows the priority bad key (01) > closed window (10) > illegal access (11) > overflow (00).
- R12: `rd_data` always reads 0x9A; reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_byte | input | 8 | Static configuration byte (run enable, period select, window select) |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Data written to the service register |
| bit_op | input | 1 | Strobe marking a single-bit manipulation of the service register |
| illegal_acc | input | 1 | Illegal memory access flag from the system |
| rd_data | output | 8 | Read value of the service register (constant) |
| rst_req | output | 1 | One-cycle internal reset request |
| rst_cause | output | 2 | Cause of the request: 00 overflow, 01 bad key, 10 closed window, 11 illegal access |

## Verification
Every request caused by a write, a strobe or the illegal-access flag is registered, so it appears on `rst_req` and `rst_cause` one rising edge after the cycle that carried the stimulus; the bench drives on the falling edge, waits for the next rising edge and samples on the following falling edge. An overflow request appears exactly T+1 rising edges after reset release or the last clear, so the bench counts T edges, checks that nothing has fired, then steps one edge and checks the pulse. The count seen by a key write equals the number of rising edges waited since the last clear, which lets the bench place writes one count before and exactly at the window edge and at T.

// File: rtl/wdw_pkg.sv
`timescale 1ns/1ps
package wdw_pkg;

    localparam int          SEL_W      = 3;
    localparam logic [7:0]  KEY_VALUE  = 8'hAC;
    localparam logic [7:0]  READ_VALUE = 8'h9A;

    typedef enum logic [1:0] {
        CAUSE_OVF = 2'd0,
        CAUSE_KEY = 2'd1,
        CAUSE_WIN = 2'd2,
        CAUSE_ILL = 2'd3
    } cause_e;

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] period_sel;
        logic [1:0]       win_sel;
    } wdw_cfg_t;

endpackage

// File: rtl/wdw_limits.sv
`timescale 1ns/1ps
module wdw_limits #(
    parameter int CNT_W     = 16,
    parameter int BASE_LOG2 = 10,
    parameter int SEL_W     = 3
) (
    input  logic [SEL_W-1:0] period_sel,
    input  logic [1:0]       win_sel,
    output logic [CNT_W-1:0] term_cnt,
    output logic [CNT_W-1:0] open_start
);
    localparam int NSEL    = 1 << SEL_W;
    localparam int MAX_EXP = CNT_W - BASE_LOG2;

    logic [CNT_W:0]   span_tab [NSEL];
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] quarter;

    for (genvar i = 0; i < NSEL; i++) begin : g_span
        localparam int EXP = (i > MAX_EXP) ? MAX_EXP : i;
        assign span_tab[i] = (CNT_W+1)'(1) << (BASE_LOG2 + EXP);
    end

    assign span     = span_tab[period_sel];
    assign term_cnt = span[CNT_W-1:0] - CNT_W'(1);
    assign quarter  = CNT_W'(span >> 2);

    always_comb begin
        case (win_sel)
            2'd0:    open_start = quarter + (quarter << 1);
            2'd1:    open_start = quarter << 1;
            2'd2:    open_start = quarter;
            default: open_start = '0;
        endcase
    end
endmodule

// File: rtl/wdw_judge.sv
`timescale 1ns/1ps
module wdw_judge
    import wdw_pkg::*;
(
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bit_op,
    input  logic       illegal_acc,
    input  logic       run,
    input  logic       first_pending,
    input  logic       win_open,
    input  logic       at_term,
    output logic       fire,
    output cause_e     cause,
    output logic       refresh_ok
);
    logic key_ok, bad_key, win_bad, ill_hit, ovf_hit;

    always_comb begin
        key_ok  = wr_en && !bit_op && (wr_data == KEY_VALUE);
        bad_key = bit_op || (wr_en && (wr_data != KEY_VALUE));
        win_bad = key_ok && !first_pending && run && !win_open;
        ill_hit = run && illegal_acc;
        ovf_hit = run && at_term && !key_ok;

        fire  = 1'b1;
        cause = CAUSE_OVF;
        if (bad_key)      cause = CAUSE_KEY;
        else if (win_bad) cause = CAUSE_WIN;
        else if (ill_hit) cause = CAUSE_ILL;
        else if (ovf_hit) cause = CAUSE_OVF;
        else              fire  = 1'b0;

        refresh_ok = key_ok && !fire;
    end
endmodule

// File: rtl/keyed_window_watchdog.sv
`timescale 1ns/1ps
module keyed_window_watchdog
    import wdw_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BASE_LOG2 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg_byte,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bit_op,
    input  logic       illegal_acc,
    output logic [7:0] rd_data,
    output logic       rst_req,
    output logic [1:0] rst_cause
);
    typedef struct packed {
        wdw_cfg_t         cfg;
        logic [CNT_W-1:0] cnt;
        logic             first;
        logic             req;
        cause_e           cause;
    } state_t;

    state_t state_d, state_q;

    logic [CNT_W-1:0] term_cnt, open_start;
    logic             fire, refresh_ok;
    cause_e           fire_cause;
    logic             en_active, first_pending;
    logic             unused_cfg;

    assign unused_cfg    = ^{cfg_byte[7], cfg_byte[0]};
    assign en_active     = state_q.cfg.run;
    assign first_pending = state_q.first;

    wdw_limits #(
        .CNT_W     (CNT_W),
        .BASE_LOG2 (BASE_LOG2),
        .SEL_W     (SEL_W)
    ) u_limits (
        .period_sel (state_q.cfg.period_sel),
        .win_sel    (state_q.cfg.win_sel),
        .term_cnt   (term_cnt),
        .open_start (open_start)
    );

    wdw_judge u_judge (
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .bit_op        (bit_op),
        .illegal_acc   (illegal_acc),
        .run           (state_q.cfg.run),
        .first_pending (state_q.first),
        .win_open      (state_q.cnt >= open_start),
        .at_term       (state_q.cnt == term_cnt),
        .fire          (fire),
        .cause         (fire_cause),
        .refresh_ok    (refresh_ok)
    );

    always_comb begin
        state_d     = state_q;
        state_d.req = 1'b0;
        if (state_q.cfg.run) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
        if (fire) begin
            state_d.req   = 1'b1;
            state_d.cause = fire_cause;
            state_d.cnt   = '0;
            state_d.first = 1'b1;
        end else if (refresh_ok) begin
            state_d.cnt   = '0;
            state_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cfg.run        <= cfg_byte[4];
            state_q.cfg.period_sel <= cfg_byte[3:1];
            state_q.cfg.win_sel    <= cfg_byte[6:5];
            state_q.cnt            <= '0;
            state_q.first          <= 1'b1;
            state_q.req            <= 1'b0;
            state_q.cause          <= CAUSE_OVF;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data   = READ_VALUE;
    assign rst_req   = state_q.req;
    assign rst_cause = state_q.cause;
endmodule

// File: rtl/wdw_checker.sv
`timescale 1ns/1ps
module wdw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       bit_op,
    input logic       illegal_acc,
    input logic       en_active,
    input logic       first_pending,
    input logic       rst_req,
    input logic [1:0] rst_cause
);
    AST_BAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != 8'hAC) |=> (rst_req && rst_cause == 2'd1)); // R6

    AST_BIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_op |=> (rst_req && rst_cause == 2'd1)); // R7

    AST_ILLEGAL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_active && illegal_acc && !wr_en && !bit_op) |=> (rst_req && rst_cause == 2'd3)); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_active && !wr_en && !bit_op) |=> !rst_req); // R9

    AST_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (first_pending && wr_en && wr_data == 8'hAC && !bit_op && !(en_active && illegal_acc))
        |=> !rst_req); // R4

    AST_REARM_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> first_pending); // R10
endmodule

bind keyed_window_watchdog wdw_checker u_wdw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .bit_op        (bit_op),
    .illegal_acc   (illegal_acc),
    .en_active     (en_active),
    .first_pending (first_pending),
    .rst_req       (rst_req),
    .rst_cause     (rst_cause)
);

// File: tb/test_keyed_window_watchdog.sv
`timescale 1ns/1ps
module test_keyed_window_watchdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_op = 1'b0;
    logic       illegal_acc = 1'b0;
    logic [7:0] rd_data;
    logic       rst_req;
    logic [1:0] rst_cause;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyed_window_watchdog i_keyed_window_watchdog (
        .clk (clk), .rst_n (rst_n), .cfg_byte (cfg_byte),
        .wr_en (wr_en), .wr_data (wr_data), .bit_op (bit_op),
        .illegal_acc (illegal_acc), .rd_data (rd_data),
        .rst_req (rst_req), .rst_cause (rst_cause)
    );

    always begin
        @(posedge clk);
        #2;
        if (rst_n && rst_req) pulses++;
    end

    function automatic logic [7:0] mk_cfg(bit en, int n, int w);
        return {1'b0, 2'(w), en, 3'(n), 1'b0};
    endfunction

    function automatic int term_of(int n);
        return (1 << (10 + ((n > 6) ? 6 : n))) - 1;
    endfunction

    function automatic bit open_at(int n, int w, int c);
        return c >= ((term_of(n) + 1) / 4) * (3 - w);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic [7:0] cfg);
        @(negedge clk);
        rst_n = 1'b0; cfg_byte = cfg;
        wr_en = 1'b0; bit_op = 1'b0; illegal_acc = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(int j);
        if (j > 0) begin
            repeat (j) @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic op(bit we, logic [7:0] d, bit bo, bit ill);
        wr_en = we; wr_data = d; bit_op = bo; illegal_acc = ill;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; bit_op = 1'b0; illegal_acc = 1'b0;
    endtask

    task automatic expect_req(string tag, bit req, int cause);
        check(tag, int'(rst_req), int'(req));
        if (req) check(tag, int'(rst_cause), cause);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int p0;
        void'($urandom(32'h5EED_0017));

        // Reset state and constant read
        do_reset(mk_cfg(1, 0, 0));
        check("R10 reset idle", int'(rst_req), 0);
        check("R12 read value", int'(rd_data), 8'h9A);

        // R1/R2/R10: exact overflow, config change after release ignored
        cfg_byte = mk_cfg(1, 7, 3);
        p0 = pulses;
        idle(1023);
        check("R1 R2 no pulse before T+1", pulses - p0, 0);
        idle(1);
        expect_req("R2 overflow at T+1", 1, 0);
        idle(1);
        check("R10 single-cycle pulse", int'(rst_req), 0);
        idle(1022);
        check("R10 restart no early pulse", pulses - p0, 1);
        idle(1);
        expect_req("R10 second overflow", 1, 0);

        // R2: select 7 clips to 0xFFFF
        do_reset(mk_cfg(1, 7, 0));
        p0 = pulses;
        idle(65535);
        check("R2 clip no early pulse", pulses - p0, 0);
        idle(1);
        expect_req("R2 clip overflow", 1, 0);

        // R3: key at terminal count is valid and clears
        do_reset(mk_cfg(1, 1, 0));
        op(1, 8'hAC, 0, 0);
        expect_req("R4 first key at count 0", 0, 0);
        idle(2047);
        op(1, 8'hAC, 0, 0);
        expect_req("R3 key at terminal count", 0, 0);
        p0 = pulses;
        idle(2046);
        check("R3 counter cleared", pulses - p0, 0);

        // R4/R5: window edge, w=00 on n=0 opens at 768
        do_reset(mk_cfg(1, 0, 0));
        idle(5);
        op(1, 8'hAC, 0, 0);
        expect_req("R4 first key early", 0, 0);
        idle(767);
        op(1, 8'hAC, 0, 0);
        expect_req("R5 closed window at 767", 1, 2);
        idle(3);
        op(1, 8'hAC, 0, 0);
        expect_req("R4 R10 first key after request", 0, 0);
        idle(768);
        op(1, 8'hAC, 0, 0);
        expect_req("R5 open at 768", 0, 0);

        // R6, R7, R8
        idle(800);
        op(1, 8'h55, 0, 0);
        expect_req("R6 wrong value", 1, 1);
        idle(10);
        op(1, 8'hAC, 1, 0);
        expect_req("R7 bit strobe", 1, 1);
        idle(10);
        op(0, 8'h00, 0, 1);
        expect_req("R8 illegal access", 1, 3);

        // R11 priorities
        idle(2);
        op(1, 8'h00, 0, 1);
        expect_req("R11 bad key over illegal", 1, 1);
        idle(2);
        op(1, 8'hAC, 0, 0);
        idle(2);
        op(1, 8'hAC, 0, 1);
        expect_req("R11 window over illegal", 1, 2);

        // R9: disabled
        do_reset(mk_cfg(0, 0, 0));
        p0 = pulses;
        idle(2000);
        check("R9 no overflow when disabled", pulses - p0, 0);
        op(0, 8'h00, 0, 1);
        expect_req("R8 R9 illegal ignored when disabled", 0, 0);
        op(1, 8'hAC, 0, 0);
        op(1, 8'hAC, 0, 0);
        expect_req("R9 second key accepted when disabled", 0, 0);
        op(1, 8'h12, 0, 0);
        expect_req("R9 wrong value when disabled", 1, 1);
        check("R12 read value unchanged", int'(rd_data), 8'h9A);

        // Random sequences against a bench model (R4 R5 R6)
        for (int s = 0; s < 4; s++) begin
            int n = $urandom_range(0, 1);
            int w = $urandom_range(0, 3);
            bit first = 1'b1;
            do_reset(mk_cfg(1, n, w));
            for (int k = 0; k < 7; k++) begin
                int j = $urandom_range(0, term_of(n));
                logic [7:0] d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hAC;
                idle(j);
                op(1, d, 0, 0);
                if (d != 8'hAC) begin
                    expect_req("R6 random wrong value", 1, 1);
                    first = 1'b1;
                end else if (!first && !open_at(n, w, j)) begin
                    expect_req("R5 random closed window", 1, 2);
                    first = 1'b1;
                end else begin
                    expect_req("R4 R5 random accepted key", 0, 0);
                    first = 1'b0;
                end
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule